// File: doc/BRIEF.md
# Handshaked Command/Response Byte Engine

This block is the device-side protocol engine behind an 8-bit shift register. Two active-low handshake wires pace the transfer. The host owns the request wire and the device owns the acknowledge wire. The host moves one byte per handshake. It first sends a command byte, then any argument bytes. The engine gathers these bytes, using a per-command length table to learn how many arguments and response bytes each command takes. It passes the completed request to an external dispatcher, then returns the response bytes one per handshake.

Each table entry may hold a fixed length or the variable marker. For a variable argument length, the first argument byte carries the count. For a variable response length, the engine sends the actual response size as the first response byte. Commands the table marks as unknown skip the dispatcher and are answered with zero bytes. The shift register and the meaning of each command lie outside this block.

Top module: `hsk_cmd_engine`

## Requirements
- R1: After reset `dev_ack_n` is 1 and `sr_irq`, `sr_wr_en`, `proto_err` and `disp_req` are 0. The engine is idle, so the next accepted byte is treated as a command.
- R2: A rising edge on `host_req_n` while `dev_ack_n` is 0 is a release. One clock later `dev_ack_n` returns to 1, with no interrupt and no byte moved.
- R3: A falling edge on `host_req_n` while `dev_ack_n` is 1 is a byte request. One clock later `dev_ack_n` is 0.
- R4: A request in idle with `sr_h2d`=0 raises `proto_err` for one cycle. It latches nothing and raises no interrupt, so the next correct request is still taken as a command.
- R5: Every byte accepted or supplied gives a one-cycle `sr_irq` pulse in the cycle `dev_ack_n` falls.
- R6: The length value 8'hFF means variable. With a variable argument length, the first argument byte is taken as the argument count.
- R7: Arguments are stored in order until the buffer of `DEPTH` bytes is full. Extra bytes are dropped, `disp_arg_cnt` saturates at `DEPTH`, and dispatch happens once the received count equals the argument length.
- R8: Dispatch raises a single-cycle `disp_req` together with the command, the stored arguments and the stored count. A zero-argument command dispatches on its own command handshake.
- R9: Between `disp_req` and `disp_done` no handshake is serviced and `dev_ack_n` does not change. A host release made during that time is serviced after `disp_done`.
- R10: A request in the response phase with `sr_h2d`=1 raises `proto_err` and supplies no byte. The next correct request receives the pending byte.
- R11: With a variable response length, the first byte supplied is the size from `disp_rsp_size`. The next bytes are `rsp_rd_data` for indices 0 up to size-1.
- R12: With a fixed response length L, exactly L bytes are supplied. Index i gives `rsp_rd_data` when i is below the reported size, and 0 otherwise.
- R13: A command with `lut_known`=0 raises no `disp_req`. A fixed length L is answered with L zero bytes, and a variable length is answered with a single size byte of 0.
- R14: After the last response byte, the engine is idle and the following request is taken as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_n | input | 1 | Host request wire, active low |
| dev_ack_n | output | 1 | Device acknowledge wire, active low |
| sr_in | input | 8 | Byte shifted in from the host |
| sr_h2d | input | 1 | Shift direction: 1 host-to-device, 0 device-to-host |
| sr_wr_en | output | 1 | Load strobe for the outgoing byte |
| sr_wr_data | output | 8 | Outgoing byte |
| sr_irq | output | 1 | Byte-done interrupt pulse |
| proto_err | output | 1 | Direction error pulse |
| lut_cmd | output | 8 | Length-table lookup index |
| lut_known | input | 1 | Table marks the command as handled |
| lut_arg_len | input | 8 | Argument length, 8'hFF variable |
| lut_rsp_len | input | 8 | Response length, 8'hFF variable |
| disp_req | output | 1 | Dispatch strobe |
| disp_cmd | output | 8 | Command byte of the request |
| disp_arg_cnt | output | 8 | Number of stored arguments |
| disp_args | output | DEPTH*8 | Stored arguments, byte i at bits 8i+7:8i |
| disp_done | input | 1 | Dispatcher finished |
| disp_rsp_size | input | 8 | Response size reported with done |
| rsp_rd_idx | output | 8 | Response buffer read index |
| rsp_rd_data | input | 8 | Response byte at that index |

## Verification
The hardest situation to reach is a host release that arrives while the engine waits for the dispatcher. That release must be held back and serviced only after done. The bench's dispatcher model holds done back for several cycles after every request. It checks that the acknowledge wire is still low at the moment it answers, and the host task waits for the deferred release. Sweeping the argument count past the small buffer depth, and sweeping the reported response size both below and above the fixed length, reaches the dropped-byte and zero-padding cases.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RSP  = 2'd3
    } hsk_state_e;

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_RELEASE = 2'd1,
        EV_REQUEST = 2'd2
    } hsk_event_e;

    localparam logic [7:0] LEN_VAR = 8'hFF;
endpackage

// File: rtl/hsk_event_decode.sv
module hsk_event_decode
    import hsk_pkg::*;
(
    input  logic       enable,
    input  logic       host_req_n,
    input  logic       last_req_n,
    input  logic       dev_ack_n,
    output hsk_event_e ev
);
    // Only a change of the host wire is an event; the wire pair then
    // tells a release, a request, or an idle/invalid pattern (ignored).
    always_comb begin
        ev = EV_NONE;
        if (enable && (host_req_n != last_req_n)) begin
            case ({host_req_n, dev_ack_n})
                2'b10:   ev = EV_RELEASE;
                2'b01:   ev = EV_REQUEST;
                default: ev = EV_NONE;
            endcase
        end
    end
endmodule

// File: rtl/hsk_arg_store.sv
module hsk_arg_store #(
    parameter int DEPTH = 16,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDXW-1:0]    wr_idx,
    input  logic [7:0]         wr_data,
    output logic [DEPTH*8-1:0] args_flat
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [7:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_idx == IDXW'(g))) begin
                slot_q <= wr_data;
            end
        end
        assign args_flat[g*8 +: 8] = slot_q;
    end
endmodule

// File: rtl/hsk_cmd_engine.sv
module hsk_cmd_engine
    import hsk_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req_n,
    output logic               dev_ack_n,
    input  logic [7:0]         sr_in,
    input  logic               sr_h2d,
    output logic               sr_wr_en,
    output logic [7:0]         sr_wr_data,
    output logic               sr_irq,
    output logic               proto_err,
    output logic [7:0]         lut_cmd,
    input  logic               lut_known,
    input  logic [7:0]         lut_arg_len,
    input  logic [7:0]         lut_rsp_len,
    output logic               disp_req,
    output logic [7:0]         disp_cmd,
    output logic [7:0]         disp_arg_cnt,
    output logic [DEPTH*8-1:0] disp_args,
    input  logic               disp_done,
    input  logic [7:0]         disp_rsp_size,
    output logic [7:0]         rsp_rd_idx,
    input  logic [7:0]         rsp_rd_data
);
    localparam int         IDXW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [7:0] DEPTH_C = 8'(DEPTH);

    typedef struct packed {
        hsk_state_e state;
        logic       ack_n;
        logic       last_req_n;
        logic [7:0] cmd;
        logic [7:0] arg_len;
        logic       arg_var;
        logic [7:0] rsp_len;
        logic       rsp_var;
        logic       known;
        logic [7:0] rx_cnt;
        logic [7:0] st_cnt;
        logic [7:0] rsp_pos;
        logic [7:0] rsp_size;
        logic       irq;
        logic       err;
        logic       wr_en;
        logic [7:0] wr_data;
        logic       disp_req;
    } eng_regs_t;

    eng_regs_t  eng_d, eng_q;
    hsk_event_e ev;
    logic       arg_we;
    logic       waiting;

    assign waiting = (eng_q.state == ST_WAIT);

    hsk_event_decode u_dec (
        .enable     (!waiting),
        .host_req_n (host_req_n),
        .last_req_n (eng_q.last_req_n),
        .dev_ack_n  (eng_q.ack_n),
        .ev         (ev)
    );

    hsk_arg_store #(.DEPTH(DEPTH)) u_args (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (arg_we),
        .wr_idx    (eng_q.st_cnt[IDXW-1:0]),
        .wr_data   (sr_in),
        .args_flat (disp_args)
    );

    always_comb begin
        eng_d          = eng_q;
        eng_d.irq      = 1'b0;
        eng_d.err      = 1'b0;
        eng_d.wr_en    = 1'b0;
        eng_d.disp_req = 1'b0;
        arg_we         = 1'b0;

        if (waiting) begin
            // Handshakes are frozen; only the dispatcher can move us on.
            if (disp_done) begin
                eng_d.rsp_size = disp_rsp_size;
                eng_d.state    = (!eng_q.rsp_var && eng_q.rsp_len == 8'd0) ? ST_IDLE : ST_RSP;
            end
        end else if (ev == EV_RELEASE) begin
            eng_d.ack_n      = 1'b1;
            eng_d.last_req_n = host_req_n;
        end else if (ev == EV_REQUEST) begin
            eng_d.ack_n      = 1'b0;
            eng_d.last_req_n = host_req_n;
            case (eng_q.state)
                ST_IDLE: begin
                    if (!sr_h2d) begin
                        eng_d.err = 1'b1;
                    end else begin
                        eng_d.irq      = 1'b1;
                        eng_d.cmd      = sr_in;
                        eng_d.arg_len  = lut_arg_len;
                        eng_d.arg_var  = (lut_arg_len == LEN_VAR);
                        eng_d.rsp_len  = lut_rsp_len;
                        eng_d.rsp_var  = (lut_rsp_len == LEN_VAR);
                        eng_d.known    = lut_known;
                        eng_d.rx_cnt   = 8'd0;
                        eng_d.st_cnt   = 8'd0;
                        eng_d.rsp_pos  = 8'd0;
                        eng_d.rsp_size = 8'd0;
                        eng_d.state    = ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (!sr_h2d) begin
                        eng_d.err = 1'b1;
                    end else begin
                        eng_d.irq = 1'b1;
                        if (eng_q.arg_var) begin
                            eng_d.arg_len = sr_in;
                            eng_d.arg_var = 1'b0;
                        end else begin
                            eng_d.rx_cnt = eng_q.rx_cnt + 8'd1;
                            if (eng_q.st_cnt < DEPTH_C) begin
                                arg_we       = 1'b1;
                                eng_d.st_cnt = eng_q.st_cnt + 8'd1;
                            end
                        end
                    end
                end
                ST_RSP: begin
                    if (sr_h2d) begin
                        eng_d.err = 1'b1;
                    end else begin
                        eng_d.irq   = 1'b1;
                        eng_d.wr_en = 1'b1;
                        if (eng_q.rsp_var) begin
                            eng_d.wr_data = eng_q.rsp_size;
                            eng_d.rsp_len = eng_q.rsp_size;
                            eng_d.rsp_var = 1'b0;
                        end else begin
                            eng_d.wr_data = (eng_q.known && eng_q.rsp_pos < eng_q.rsp_size)
                                            ? rsp_rd_data : 8'd0;
                            eng_d.rsp_pos = eng_q.rsp_pos + 8'd1;
                        end
                    end
                end
                default: ;
            endcase

            // Completion checks, evaluated on the values just computed.
            if (eng_d.state == ST_CMD && !eng_d.arg_var && eng_d.rx_cnt == eng_d.arg_len) begin
                if (eng_d.known) begin
                    eng_d.disp_req = 1'b1;
                    eng_d.state    = ST_WAIT;
                end else begin
                    eng_d.state = ST_RSP;
                end
            end
            if (eng_d.state == ST_RSP && !eng_d.rsp_var && eng_d.rsp_pos == eng_d.rsp_len) begin
                eng_d.state = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q            <= '0;
            eng_q.state      <= ST_IDLE;
            eng_q.ack_n      <= 1'b1;
            eng_q.last_req_n <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign dev_ack_n    = eng_q.ack_n;
    assign sr_wr_en     = eng_q.wr_en;
    assign sr_wr_data   = eng_q.wr_data;
    assign sr_irq       = eng_q.irq;
    assign proto_err    = eng_q.err;
    assign lut_cmd      = sr_in;
    assign disp_req     = eng_q.disp_req;
    assign disp_cmd     = eng_q.cmd;
    assign disp_arg_cnt = eng_q.st_cnt;
    assign rsp_rd_idx   = eng_q.rsp_pos;
endmodule

// File: rtl/hsk_cmd_engine_chk.sv
module hsk_cmd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic host_req_n,
    input logic dev_ack_n,
    input logic sr_h2d,
    input logic sr_wr_en,
    input logic sr_irq,
    input logic proto_err,
    input logic disp_req,
    input logic disp_done,
    input logic waiting
);
    assert_ack_rise_on_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ack_n) |-> $past(host_req_n));

    assert_ack_fall_on_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_ack_n) |-> !$past(host_req_n));

    assert_err_moves_nothing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (!sr_irq && !sr_wr_en));

    assert_irq_with_ack_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sr_irq |-> !dev_ack_n);

    assert_disp_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_req |=> !disp_req);

    assert_wait_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !disp_done) |=> ($stable(dev_ack_n) && !sr_irq));

    assert_supply_direction_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_en |-> !$past(sr_h2d));
endmodule

bind hsk_cmd_engine hsk_cmd_engine_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req_n (host_req_n),
    .dev_ack_n  (dev_ack_n),
    .sr_h2d     (sr_h2d),
    .sr_wr_en   (sr_wr_en),
    .sr_irq     (sr_irq),
    .proto_err  (proto_err),
    .disp_req   (disp_req),
    .disp_done  (disp_done),
    .waiting    (waiting)
);

// File: tb/hsk_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module hsk_cmd_engine_tb_top;
    localparam int DEPTH = 4;
    localparam int DLY   = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_req_n = 1'b1;
    logic               dev_ack_n;
    logic [7:0]         sr_in = 8'd0;
    logic               sr_h2d = 1'b1;
    logic               sr_wr_en;
    logic [7:0]         sr_wr_data;
    logic               sr_irq;
    logic               proto_err;
    logic [7:0]         lut_cmd;
    logic               lut_known;
    logic [7:0]         lut_arg_len;
    logic [7:0]         lut_rsp_len;
    logic               disp_req;
    logic [7:0]         disp_cmd;
    logic [7:0]         disp_arg_cnt;
    logic [DEPTH*8-1:0] disp_args;
    logic               disp_done = 1'b0;
    logic [7:0]         disp_rsp_size = 8'd0;
    logic [7:0]         rsp_rd_idx;
    logic [7:0]         rsp_rd_data;

    int total = 0;
    int bad   = 0;

    // Dispatcher-side capture
    logic [7:0]         d_cmd = 8'd0;
    logic [7:0]         d_cnt = 8'd0;
    logic [DEPTH*8-1:0] d_args = '0;
    logic [7:0]         d_size = 8'd0;
    int                 d_reqs = 0;

    always #2 clk = ~clk;

    // Length table: high nibble 0 is known; [1:0] args, [3:2] response, code 3 variable.
    assign lut_known   = (lut_cmd[7:4] == 4'd0);
    assign lut_arg_len = (lut_cmd[1:0] == 2'd3) ? 8'hFF : {6'd0, lut_cmd[1:0]};
    assign lut_rsp_len = (lut_cmd[3:2] == 2'd3) ? 8'hFF : {6'd0, lut_cmd[3:2]};
    assign rsp_rd_data = (d_cmd ^ 8'h30) + rsp_rd_idx;

    hsk_cmd_engine #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req_n(host_req_n), .dev_ack_n(dev_ack_n),
        .sr_in(sr_in), .sr_h2d(sr_h2d), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .sr_irq(sr_irq), .proto_err(proto_err), .lut_cmd(lut_cmd), .lut_known(lut_known),
        .lut_arg_len(lut_arg_len), .lut_rsp_len(lut_rsp_len), .disp_req(disp_req),
        .disp_cmd(disp_cmd), .disp_arg_cnt(disp_arg_cnt), .disp_args(disp_args),
        .disp_done(disp_done), .disp_rsp_size(disp_rsp_size), .rsp_rd_idx(rsp_rd_idx),
        .rsp_rd_data(rsp_rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Dispatcher model: answers each request DLY cycles later.
    initial begin
        forever begin
            @(negedge clk);
            if (disp_req) begin
                d_reqs++;
                d_cmd  = disp_cmd;
                d_cnt  = disp_arg_cnt;
                d_args = disp_args;
                d_size = 8'((int'(disp_cmd[3:0]) + int'(disp_arg_cnt)) % 5);
                repeat (DLY) @(negedge clk);
                chk(dev_ack_n == 1'b0, "R9 ack held while dispatching", int'(dev_ack_n), 0);
                disp_done     = 1'b1;
                disp_rsp_size = d_size;
                @(negedge clk);
                disp_done = 1'b0;
            end
        end
    end

    task automatic wait_ack_high();
        for (int k = 0; k < 200 && !dev_ack_n; k++) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        @(negedge clk);
        sr_h2d = 1'b1; sr_in = b; host_req_n = 1'b0;
        @(negedge clk);
        chk(!dev_ack_n && sr_irq, {tag, " R3 R5 ack low with irq on accepted byte"},
            int'({dev_ack_n, sr_irq}), 1);
        host_req_n = 1'b1;
        @(negedge clk);
        wait_ack_high();
    endtask

    task automatic recv_byte(output logic [7:0] b);
        @(negedge clk);
        sr_h2d = 1'b0; host_req_n = 1'b0;
        @(negedge clk);
        chk(sr_irq && sr_wr_en && !dev_ack_n, "R5 irq and load on supplied byte",
            int'({sr_irq, sr_wr_en, dev_ack_n}), 6);
        b = sr_wr_data;
        host_req_n = 1'b1;
        @(negedge clk);
        chk(dev_ack_n == 1'b1, "R2 release seen one cycle later", int'(dev_ack_n), 1);
    endtask

    function automatic logic [7:0] exp_data(input logic [7:0] c, input int i);
        return (c ^ 8'h30) + 8'(i);
    endfunction

    task automatic run_txn(input logic [7:0] c, input int nvar);
        int          nargs, stored, reqs0, size, rlen;
        bit          known, avar, rvar;
        logic [7:0]  b;
        known = (c[7:4] == 4'd0);
        avar  = (c[1:0] == 2'd3);
        rvar  = (c[3:2] == 2'd3);
        nargs = avar ? nvar : int'(c[1:0]);
        rlen  = int'(c[3:2]);
        reqs0 = d_reqs;
        send_byte(c, "cmd");
        if (avar) send_byte(8'(nargs), "R6 length byte");
        for (int i = 0; i < nargs; i++) send_byte(8'hA0 + 8'(i), "arg");
        stored = (nargs < DEPTH) ? nargs : DEPTH;
        if (known) begin
            chk(d_reqs == reqs0 + 1, "R8 one dispatch per command", d_reqs - reqs0, 1);
            chk(d_cmd == c, "R8 dispatched command", int'(d_cmd), int'(c));
            chk(int'(d_cnt) == stored, "R6 R7 stored argument count", int'(d_cnt), stored);
            for (int i = 0; i < stored; i++)
                chk(d_args[i*8 +: 8] == 8'hA0 + 8'(i), "R7 stored argument",
                    int'(d_args[i*8 +: 8]), int'(8'hA0 + 8'(i)));
            size = (int'(c[3:0]) + stored) % 5;
        end else begin
            chk(d_reqs == reqs0, "R13 unknown command not dispatched", d_reqs - reqs0, 0);
            size = 0;
        end
        if (rvar) begin
            recv_byte(b);
            chk(int'(b) == size, "R11 R13 size byte first", int'(b), size);
            for (int i = 0; i < size; i++) begin
                recv_byte(b);
                chk(b == exp_data(c, i), "R11 variable response byte", int'(b),
                    int'(exp_data(c, i)));
            end
        end else begin
            for (int i = 0; i < rlen; i++) begin
                recv_byte(b);
                chk(b == ((known && i < size) ? exp_data(c, i) : 8'd0),
                    "R12 R13 fixed response byte", int'(b),
                    int'((known && i < size) ? exp_data(c, i) : 8'd0));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_up();
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        chk(dev_ack_n && !sr_irq && !sr_wr_en && !proto_err && !disp_req,
            "R1 reset outputs", int'({dev_ack_n, sr_irq, sr_wr_en, proto_err, disp_req}), 16);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dev_ack_n == 1'b1, "R1 ack idle after reset", int'(dev_ack_n), 1);

        // R4: wrong direction in idle
        sr_h2d = 1'b0; sr_in = 8'h05; host_req_n = 1'b0;
        @(negedge clk);
        chk(proto_err && !sr_irq && !dev_ack_n, "R4 idle direction error",
            int'({proto_err, sr_irq, dev_ack_n}), 4);
        host_req_n = 1'b1;
        @(negedge clk);
        chk(dev_ack_n == 1'b1, "R2 release after error", int'(dev_ack_n), 1);
        run_txn(8'h05, 0);

        // R10: wrong direction in the response phase (cmd 8'h04: 0 args, 1 byte back)
        send_byte(8'h04, "R10 cmd");
        @(negedge clk);
        sr_h2d = 1'b1; host_req_n = 1'b0;
        @(negedge clk);
        chk(proto_err && !sr_wr_en, "R10 response direction error",
            int'({proto_err, sr_wr_en}), 2);
        host_req_n = 1'b1;
        @(negedge clk);
        recv_byte(b);
        chk(b == exp_data(8'h04, 0), "R10 pending byte after error", int'(b),
            int'(exp_data(8'h04, 0)));

        // Sweep every known command; variable arguments from 0 to DEPTH+3
        for (int c = 0; c < 16; c++) begin
            if (c[1:0] == 2'd3) begin
                for (int n = 0; n <= DEPTH + 3; n++) run_txn(8'(c), n);
            end else begin
                run_txn(8'(c), 0);
            end
        end
        // Unknown commands
        for (int c = 8'h50; c < 8'h60; c++) run_txn(8'(c), 2);
        // R14: back in idle, a fresh command is accepted
        run_txn(8'h0A, 0);
        chk(d_cmd == 8'h0A, "R14 new command after response", int'(d_cmd), 10);
        finish_up();
    end
endmodule